// File: doc/BRIEF.md
# Headphone Output Enable Sequencer

This block brings a stereo headphone driver up and down in a safe order. Each channel has its own state machine and its own request. Each channel drives four control lines that must rise in a fixed sequence. First comes the amplifier enable. A timed delayed enable follows, at least 20 µs later. The output stage is enabled only once the DC servo reports that offset cancellation is complete. The output-short removal comes last, one cycle after the output stage is on.

When a request is withdrawn, the channel tears down in the reverse order. Short removal clears first, then the output stage. The amplifier and delayed enables then clear together, in the same cycle. A request that drops part way through power-up starts the teardown from whatever point the channel had reached. The microsecond time base comes from a parameterised prescaler that divides an incoming tick (`TICK_DIV` ticks per µs). The minimum gap is `DLY_US` microseconds.

The eight control lines are packed into one status word. A per-channel ready flag reports that the channel is fully up.

Top module: `hp_enable_sequencer`

## Requirements
- R1: While reset is asserted, and just after it, all eight status bits and both ready flags are 0.
- R2: From idle, the amplifier enable of a channel rises on the first clock edge that samples that channel's request high.
- R3: The delayed enable rises on the clock edge that samples the (DLY_US+1)-th microsecond pulse counted while that channel has only its amplifier enable set. The count starts again from zero each time the amplifier enable is freshly asserted.
- R4: The output-stage enable rises on the clock edge that samples the channel's servo-done input high while the delayed enable is set. It stays low for as long as servo-done is low.
- R5: Short removal rises exactly one cycle after the output-stage enable, and never while the output stage is off.
- R6: Status bits 7..4 belong to the left channel and bits 3..0 to the right. Within each nibble, from the top bit down, the order is short removal, output stage, delayed enable, amplifier enable.
- R7: ready_o[1] (left) and ready_o[0] (right) are high exactly when all four enables of that channel are set.
- R8: On a request drop from the fully-up state, short removal clears on the next edge. The output stage clears one cycle later, and the amplifier and delayed enables clear one cycle after that.
- R9: A request drop with only the amplifier enable set, or with amplifier and delayed enables set, clears everything on the next edge. A drop with the output stage on but short removal not yet set clears the output stage first, then the amplifier and delayed enables on the following edge.
- R10: The delayed enable never stays set when the amplifier enable clears; both clear in the same cycle.
- R11: A request that is raised again during teardown does not interrupt it. The channel finishes at idle and only then restarts at the amplifier enable.
- R12: The two channels operate independently; one channel's inputs never change the other channel's status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base timing tick; TICK_DIV of them make one microsecond |
| req_l_i | input | 1 | Left channel power request |
| req_r_i | input | 1 | Right channel power request |
| servo_done_l_i | input | 1 | Left DC-servo offset cancellation complete |
| servo_done_r_i | input | 1 | Right DC-servo offset cancellation complete |
| hp_status_o | output | 8 | Packed enables, left in 7..4, right in 3..0 |
| ready_o | output | 2 | Per-channel fully-up flag, bit 1 left, bit 0 right |

## Verification
The bench hand-feeds microsecond pulses and checks that the delayed enable is still low after the DLY_US-th pulse and high after the next one. An off-by-one counter would enable the stage a microsecond early or late. A fresh request after an aborted power-up must count the full delay again; a counter that did not restart would fire early. Teardown is checked cycle by cycle from the fully-up state, from the delayed state and from the output-stage-only state. A design that cleared lines together or in the wrong order would show the wrong intermediate status word. A request re-raised mid-teardown must still pass through idle, which catches a state machine that jumps straight back to full power.

// File: rtl/hpseq_pkg.sv
package hpseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_AMP    = 3'd1,
      ST_DLY    = 3'd2,
      ST_OUT    = 3'd3,
      ST_FULL   = 3'd4,
      ST_SD_OUT = 3'd5,
      ST_SD_AMP = 3'd6
   } hp_state_e;

   // Field order fixes the packed status nibble (R6): top bit first.
   typedef struct packed {
      logic rmv_short;
      logic out_en;
      logic dly_en;
      logic amp_en;
   } hp_ctl_t;

endpackage

// File: rtl/hpseq_prescaler.sv
module hpseq_prescaler #(
   parameter int unsigned TICK_DIV = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   output logic us_pulse_o
);
   localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

   if (TICK_DIV < 1) begin : g_bad_div
      $error("hpseq_prescaler: TICK_DIV must be at least 1");
   end

   logic [CNT_W-1:0] div_q;

   assign us_pulse_o = tick_i && (div_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q <= '0;
      end else if (tick_i) begin
         if (div_q == LAST) div_q <= '0;
         else               div_q <= div_q + 1'b1;
      end
   end

endmodule

// File: rtl/hpseq_channel.sv
module hpseq_channel
   import hpseq_pkg::*;
#(
   parameter int unsigned DLY_US = 20
) (
   input  logic    clk_i,
   input  logic    rst_ni,
   input  logic    us_pulse_i,
   input  logic    req_i,
   input  logic    servo_done_i,
   output hp_ctl_t ctl_o,
   output logic    ready_o
);
   localparam int unsigned WAIT_PULSES = DLY_US + 1;
   localparam int unsigned CNT_W       = $clog2(WAIT_PULSES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_PULSES - 1);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WAIT_PULSES);

   if (DLY_US < 1) begin : g_bad_dly
      $error("hpseq_channel: DLY_US must be at least 1");
   end

   hp_state_e        state_q, state_d;
   logic [CNT_W-1:0] cnt_q;
   logic             dly_done;

   assign dly_done = us_pulse_i && (cnt_q == CNT_LAST);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (req_i) state_d = ST_AMP;
         ST_AMP:    if (!req_i) state_d = ST_IDLE;
                    else if (dly_done) state_d = ST_DLY;
         ST_DLY:    if (!req_i) state_d = ST_IDLE;
                    else if (servo_done_i) state_d = ST_OUT;
         ST_OUT:    if (!req_i) state_d = ST_SD_AMP;
                    else state_d = ST_FULL;
         ST_FULL:   if (!req_i) state_d = ST_SD_OUT;
         ST_SD_OUT: state_d = ST_SD_AMP;
         ST_SD_AMP: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   // Delay counter: only runs with the amplifier alone on, cleared elsewhere.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (state_q != ST_AMP) cnt_q <= '0;
      else if (us_pulse_i)        cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      ctl_o = '0;
      unique case (state_q)
         ST_AMP:    ctl_o = '{rmv_short: 1'b0, out_en: 1'b0, dly_en: 1'b0, amp_en: 1'b1};
         ST_DLY,
         ST_SD_AMP: ctl_o = '{rmv_short: 1'b0, out_en: 1'b0, dly_en: 1'b1, amp_en: 1'b1};
         ST_OUT,
         ST_SD_OUT: ctl_o = '{rmv_short: 1'b0, out_en: 1'b1, dly_en: 1'b1, amp_en: 1'b1};
         ST_FULL:   ctl_o = '{rmv_short: 1'b1, out_en: 1'b1, dly_en: 1'b1, amp_en: 1'b1};
         default:   ctl_o = '0;
      endcase
   end

   assign ready_o = (state_q == ST_FULL);

   // Independent pulse tally since the amplifier came on, for the delay check.
   logic [CNT_W-1:0] chk_pulses_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              chk_pulses_q <= '0;
      else if (!ctl_o.amp_en)                   chk_pulses_q <= '0;
      else if (!ctl_o.dly_en && us_pulse_i &&
               chk_pulses_q != CNT_SAT)         chk_pulses_q <= chk_pulses_q + 1'b1;
   end

   // R3
   min_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ctl_o.dly_en) |-> (chk_pulses_q >= CNT_SAT));

   // R4
   servo_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ctl_o.out_en) |-> $past(servo_done_i) && $past(ctl_o.dly_en));

   // R5
   short_after_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ctl_o.rmv_short) |-> $past(ctl_o.out_en));

   // R10
   dly_with_amp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ctl_o.amp_en) |-> !ctl_o.dly_en);

   // R10
   dly_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ctl_o.dly_en) |-> $fell(ctl_o.amp_en));

   // R8
   out_off_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ctl_o.out_en) |-> !$past(ctl_o.rmv_short) && ctl_o.amp_en);

endmodule

// File: rtl/hp_enable_sequencer.sv
module hp_enable_sequencer
   import hpseq_pkg::*;
#(
   parameter int unsigned TICK_DIV = 1,
   parameter int unsigned DLY_US   = 20
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       req_l_i,
   input  logic       req_r_i,
   input  logic       servo_done_l_i,
   input  logic       servo_done_r_i,
   output logic [7:0] hp_status_o,
   output logic [1:0] ready_o
);
   localparam int unsigned NUM_CH = 2;
   localparam int unsigned CTL_W  = $bits(hp_ctl_t);

   if (NUM_CH * CTL_W != 8) begin : g_bad_pack
      $error("hp_enable_sequencer: status word must be 8 bits");
   end

   logic              us_pulse;
   logic [NUM_CH-1:0] req_v, done_v, rdy_v;
   hp_ctl_t           ctl_v [NUM_CH];

   // Index 1 is the left channel, index 0 the right (R6).
   assign req_v  = {req_l_i, req_r_i};
   assign done_v = {servo_done_l_i, servo_done_r_i};

   hpseq_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .us_pulse_o (us_pulse)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      hpseq_channel #(.DLY_US(DLY_US)) u_chan (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .us_pulse_i   (us_pulse),
         .req_i        (req_v[ch]),
         .servo_done_i (done_v[ch]),
         .ctl_o        (ctl_v[ch]),
         .ready_o      (rdy_v[ch])
      );
      assign hp_status_o[ch*CTL_W +: CTL_W] = ctl_v[ch];
   end

   assign ready_o = rdy_v;

   // R7
   ready_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o[1] |-> (hp_status_o[7:4] == 4'hF));

   // R7
   ready_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o[0] |-> (hp_status_o[3:0] == 4'hF));

endmodule

// File: tb/hp_enable_sequencer_tb.sv
`timescale 1ns/100ps
module hp_enable_sequencer_tb_top;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       tick_i = 1'b0;
   logic       req_l_i = 1'b0, req_r_i = 1'b0;
   logic       servo_done_l_i = 1'b0, servo_done_r_i = 1'b0;
   logic [7:0] hp_status_o;
   logic [1:0] ready_o;

   int  n_chk = 0, n_fail = 0;
   bit  auto_tick = 1'b0;
   int  tph = 0;
   bit  finished = 1'b0;

   always #2.5 clk_i = ~clk_i;

   hp_enable_sequencer #(.TICK_DIV(1), .DLY_US(20)) dut_i (
      .clk_i, .rst_ni, .tick_i, .req_l_i, .req_r_i,
      .servo_done_l_i, .servo_done_r_i, .hp_status_o, .ready_o
   );

   // fields: req{L,R}, done{L,R}, cycles, expected status, expected ready
   localparam int NV = 9;
   localparam logic [29:0] VECS [NV] = '{
      {2'b00, 2'b00, 16'd5,   8'h00, 2'b00},
      {2'b10, 2'b00, 16'd200, 8'h30, 2'b00},
      {2'b10, 2'b10, 16'd5,   8'hF0, 2'b10},
      {2'b11, 2'b10, 16'd200, 8'hF3, 2'b10},
      {2'b11, 2'b11, 16'd5,   8'hFF, 2'b11},
      {2'b01, 2'b11, 16'd5,   8'h0F, 2'b01},
      {2'b00, 2'b11, 16'd5,   8'h00, 2'b00},
      {2'b11, 2'b11, 16'd200, 8'hFF, 2'b11},
      {2'b00, 2'b00, 16'd5,   8'h00, 2'b00}
   };

   // Wait one full cycle; ends just after a falling edge, where inputs change.
   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk_i);
         tick_i = auto_tick && (tph == 0);
         tph = (tph + 1) % 4;
      end
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         tick_i = 1'b1;
         cyc(1);
      end
   endtask

   task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: status/ready actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_st(input string req, input logic [7:0] exp);
      chk(req, {2'b00, hp_status_o}, {2'b00, exp});
   endtask

   initial begin
      // R1: reset state
      cyc(3);
      chk("R1 in reset", {hp_status_o, ready_o}, 10'h000);
      rst_ni = 1'b1;
      cyc(1);
      chk("R1 after reset", {hp_status_o, ready_o}, 10'h000);

      // Vector walk, R6 R7 R12 packing and independence
      auto_tick = 1'b1;
      for (int v = 0; v < NV; v++) begin
         {req_l_i, req_r_i}               = VECS[v][29:28];
         {servo_done_l_i, servo_done_r_i} = VECS[v][27:26];
         cyc(int'(VECS[v][25:10]));
         chk($sformatf("R6/R7/R12 vector %0d", v), {hp_status_o, ready_o}, VECS[v][9:0]);
      end
      auto_tick = 1'b0;
      cyc(1);

      // R2 / R3: exact delay with hand-fed pulses
      req_l_i = 1'b1; servo_done_l_i = 1'b0;
      cyc(1);
      chk_st("R2 amp one cycle after request", 8'h10);
      pulses(20);
      chk_st("R3 no delayed enable after DLY_US pulses", 8'h10);
      pulses(1);
      chk_st("R3 delayed enable on next pulse", 8'h30);
      cyc(10);
      chk_st("R4 output stage waits for servo", 8'h30);

      // R4 / R5
      servo_done_l_i = 1'b1;
      cyc(1);
      chk_st("R4 output stage after servo done", 8'h70);
      cyc(1);
      chk("R5 short removal follows", {hp_status_o, ready_o}, {8'hF0, 2'b10});

      // R8 teardown from full
      req_l_i = 1'b0;
      cyc(1);
      chk_st("R8 short removal clears first", 8'h70);
      cyc(1);
      chk_st("R8 output stage clears second", 8'h30);
      cyc(1);
      chk_st("R8 amp and delayed clear together", 8'h00);

      // R3 restart after aborted power-up, R9 amp-only drop
      servo_done_l_i = 1'b0;
      req_l_i = 1'b1;
      cyc(1);
      pulses(10);
      req_l_i = 1'b0;
      cyc(1);
      chk_st("R9 drop with amp only", 8'h00);
      req_l_i = 1'b1;
      cyc(1);
      pulses(20);
      chk_st("R3 counter restarted", 8'h10);
      pulses(1);
      chk_st("R3 delay after restart", 8'h30);

      // R9 / R10 drop in delayed state
      req_l_i = 1'b0;
      cyc(1);
      chk_st("R10 amp and delayed clear in one cycle", 8'h00);

      // R9 drop with output stage on, short not yet set
      req_l_i = 1'b1;
      cyc(1);
      pulses(21);
      chk_st("R9 setup delayed", 8'h30);
      servo_done_l_i = 1'b1;
      cyc(1);
      chk_st("R9 output stage on", 8'h70);
      req_l_i = 1'b0;
      cyc(1);
      chk_st("R9 output stage clears, no short", 8'h30);
      cyc(1);
      chk_st("R9 then idle", 8'h00);

      // R11 re-request during teardown
      req_l_i = 1'b1;
      cyc(1);
      pulses(21);
      chk_st("R11 setup delayed", 8'h30);
      cyc(1);
      chk_st("R11 setup output", 8'h70);
      cyc(1);
      chk_st("R11 setup full", 8'hF0);
      req_l_i = 1'b0;
      cyc(1);
      chk_st("R11 teardown begins", 8'h70);
      req_l_i = 1'b1;
      cyc(1);
      chk_st("R11 teardown continues", 8'h30);
      cyc(1);
      chk_st("R11 reaches idle", 8'h00);
      cyc(1);
      chk_st("R11 restarts at amp", 8'h10);

      // R12 right channel idle while left works, then R1 reset mid-run
      chk("R12 right untouched", {6'b0, hp_status_o[3:0]}, 10'h000);
      rst_ni = 1'b0;
      cyc(1);
      chk("R1 reset mid-run", {hp_status_o, ready_o}, 10'h000);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #750000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule